// File: doc/BRIEF.md
# Character-Cell Raster Timing Generator

This block produces the beam timing for a display built from character cells. It steps once per character clock. From a set of programmed values it drives horizontal sync, vertical sync, a display-enable flag, the raster line inside the current character row, and a 14-bit video memory address. Pixel-fetch logic uses that address to read video RAM. The programmed values arrive as plain parallel inputs and are held steady by whatever owns them. The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or status signal.

Internally the block is a chain of counters. A character counter runs along each scanline. A raster counter runs down each character row. A row counter runs down the screen. An optional trailing phase of extra scanlines follows the last row. Comparators on these counters shape the sync pulses and the visible window. The address generator keeps a row-start latch so that every scanline of a character row refetches the same span of memory. The address is loaded from the start-address pair only at the top of each screen.

Top module: `crt_raster_gen`

## Requirements
- R1: The character position counts 0, 1, … `h_total` and then returns to 0, so every scanline lasts `h_total`+1 clock cycles.
- R2: `disp_en` is high only while the character position is below `h_disp`, the row count is below `v_disp`, and the frame is not in its trailing adjust scanlines.
- R3: `hsync` goes high in the cycle where the character position equals `h_sync_pos`. It stays high for the number of characters in `sync_widths[3:0]`, and a value of 0 in that field means 16.
- R4: `vsync` goes high at character 0 of raster 0 of row `v_sync_pos`. It stays high for the number of scanlines in `sync_widths[7:4]`, and a value of 0 in that field means 16.
- R5: `row_addr` counts scanlines inside a character row from 0 to `max_raster`. When it wraps, the row count advances. During the adjust phase it counts the adjust scanlines from 0.
- R6: After row `v_total`, `v_adjust` extra scanlines run before a new screen starts. A frame therefore lasts (`v_total`+1)·(`max_raster`+1)+`v_adjust` scanlines.
- R7: At the first character of each screen (row 0, raster 0), `mem_addr` equals {`start_hi`,`start_lo`}: the upper 6 bits come from `start_hi` and the lower 8 bits from `start_lo`.
- R8: `mem_addr` rises by one per character, wrapping modulo 2^14. Each new scanline restarts from the row-start latch. On the last raster of a character row, the latch takes the address present at character `h_disp`. If that character is the last one on the line, the address simply carries on.
- R9: While `rst_n` is low at a clock edge, all counters clear and `mem_addr` takes the start-address pair, so after reset the outputs show character 0, raster 0, row 0.
- R10: With `h_total`=63, `h_disp`=40, `h_sync_pos`=46, `sync_widths`=0x8E, `v_total`=38, `v_adjust`=0, `v_disp`=25, `v_sync_pos`=30, `max_raster`=7 and start 0x2000, hsync repeats every 64 cycles and vsync every 312 scanlines (19968 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_total | input | 8 | Last character position of a scanline |
| h_disp | input | 8 | Character position where the visible part of a line ends |
| h_sync_pos | input | 8 | Character position where horizontal sync starts |
| sync_widths | input | 8 | [3:0] horizontal sync characters, [7:4] vertical sync scanlines (0 means 16) |
| v_total | input | 7 | Last character row of a screen |
| v_adjust | input | 5 | Extra scanlines after the last row |
| v_disp | input | 7 | First character row that is blanked |
| v_sync_pos | input | 7 | Character row where vertical sync starts |
| max_raster | input | 5 | Last raster line of a character row |
| start_hi | input | 6 | Upper bits of the screen start address |
| start_lo | input | 8 | Lower bits of the screen start address |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Visible-area flag |
| mem_addr | output | 14 | Video memory address of the current character |
| row_addr | output | 5 | Raster line inside the current character row |

## Verification
The bench targets five corner cases:
- A sync width field of zero. A design that used the field literally would give no pulse instead of 16.
- A display-end column equal to the last column. Here the row latch and the line wrap fall in the same cycle, and a wrong ordering would repeat or skip a row of memory.
- A start address near the top of the 14-bit space. A design that widened instead of wrapping would leave the address space.
- A non-zero adjust count. A design that miscounted it would give the wrong frame length, or keep display enabled, or advance the row count during the extra lines.
- A blanking row beyond the last row. A design that miscompared would blank the whole screen.

In every case the bench checks the line and frame periods and the sync widths against figures computed from the programmed values, while a behavioural model checks each output on every cycle.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;

  localparam int unsigned SYNC_FIELD_W = 4;
  localparam int unsigned SYNC_LEN_W   = SYNC_FIELD_W + 1;

  typedef enum logic {
    PH_ROWS   = 1'b0,
    PH_ADJUST = 1'b1
  } vphase_t;

  // A zero-width field stands for the longest pulse the field can express.
  function automatic logic [SYNC_LEN_W-1:0] sync_len(input logic [SYNC_FIELD_W-1:0] field);
    if (field == '0) return SYNC_LEN_W'(1 << SYNC_FIELD_W);
    return {1'b0, field};
  endfunction

endpackage

// File: rtl/crt_hcount.sv
module crt_hcount
  import crt_timing_pkg::*;
#(
  parameter int unsigned HW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [HW-1:0]           h_total,
  input  logic [HW-1:0]           h_sync_pos,
  input  logic [SYNC_FIELD_W-1:0] hs_field,
  output logic [HW-1:0]           hcc,
  output logic                    line_end,
  output logic                    hsync
);

  localparam logic [HW-1:0]         H_ONE = HW'(1);
  localparam logic [SYNC_LEN_W-1:0] L_ONE = SYNC_LEN_W'(1);

  logic [SYNC_LEN_W-1:0] hs_left;
  logic                  hs_hit;

  assign line_end = (hcc == h_total);
  assign hs_hit   = (hcc == h_sync_pos);
  assign hsync    = hs_hit || (hs_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcc     <= '0;
      hs_left <= '0;
    end else begin
      hcc <= line_end ? '0 : hcc + H_ONE;
      if (hs_hit)
        hs_left <= sync_len(hs_field) - L_ONE;
      else if (hs_left != '0)
        hs_left <= hs_left - L_ONE;
    end
  end

  // R1
  wrap_after_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hcc == '0));

  // R3
  hsync_start_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> (hcc == h_sync_pos));

endmodule

// File: rtl/crt_vcount.sv
module crt_vcount
  import crt_timing_pkg::*;
#(
  parameter int unsigned RW = 5,
  parameter int unsigned VW = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    line_end,
  input  logic                    line_start,
  input  logic [RW-1:0]           max_raster,
  input  logic [VW-1:0]           v_total,
  input  logic [RW-1:0]           v_adjust,
  input  logic [VW-1:0]           v_disp,
  input  logic [VW-1:0]           v_sync_pos,
  input  logic [SYNC_FIELD_W-1:0] vs_field,
  output logic [RW-1:0]           rc,
  output logic                    row_last,
  output logic                    frame_start,
  output logic                    vdisp,
  output logic                    vsync
);

  localparam logic [RW-1:0]         R_ONE = RW'(1);
  localparam logic [VW-1:0]         V_ONE = VW'(1);
  localparam logic [SYNC_LEN_W-1:0] L_ONE = SYNC_LEN_W'(1);

  vphase_t               phase;
  logic [VW-1:0]         vcc;
  logic [SYNC_LEN_W-1:0] vs_left;
  logic                  last_line;
  logic                  vs_start;

  assign row_last  = (phase == PH_ROWS) && (rc == max_raster);
  assign last_line = (row_last && (vcc == v_total) && (v_adjust == '0)) ||
                     ((phase == PH_ADJUST) && (rc == v_adjust - R_ONE));
  assign frame_start = line_end && last_line;
  assign vdisp       = (phase == PH_ROWS) && (vcc < v_disp);
  assign vs_start    = line_start && (rc == '0) && (phase == PH_ROWS) &&
                       (vcc == v_sync_pos) && (vs_left == '0);
  assign vsync       = vs_start || (vs_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc    <= '0;
      vcc   <= '0;
      phase <= PH_ROWS;
    end else if (line_end) begin
      if (last_line) begin
        rc    <= '0;
        vcc   <= '0;
        phase <= PH_ROWS;
      end else if (phase == PH_ADJUST) begin
        rc <= rc + R_ONE;
      end else if (rc == max_raster) begin
        rc <= '0;
        if (vcc == v_total) phase <= PH_ADJUST;
        else                vcc   <= vcc + V_ONE;
      end else begin
        rc <= rc + R_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_left <= '0;
    end else if (vs_start) begin
      vs_left <= line_end ? sync_len(vs_field) - L_ONE : sync_len(vs_field);
    end else if (line_end && (vs_left != '0)) begin
      vs_left <= vs_left - L_ONE;
    end
  end

  // R5
  raster_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && row_last) |=> (rc == '0));

  // R4
  vsync_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> line_start);

endmodule

// File: rtl/crt_addr_gen.sv
module crt_addr_gen #(
  parameter int unsigned AW = 14,
  parameter int unsigned HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcc,
  input  logic [HW-1:0] h_disp,
  input  logic          line_end,
  input  logic          row_last,
  input  logic          frame_start,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] ma
);

  localparam logic [AW-1:0] A_ONE = AW'(1);

  logic [AW-1:0] row_base;
  logic          capture;

  assign capture = row_last && (hcc == h_disp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ma       <= start_addr;
      row_base <= start_addr;
    end else if (frame_start) begin
      ma       <= start_addr;
      row_base <= start_addr;
    end else begin
      if (capture) row_base <= ma;
      if (line_end) ma <= capture ? ma : row_base;
      else          ma <= ma + A_ONE;
    end
  end

  // R7
  top_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (ma == $past(start_addr)));

  // R8
  step_per_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> (ma == $past(ma) + A_ONE));

endmodule

// File: rtl/crt_raster_gen.sv
module crt_raster_gen
  import crt_timing_pkg::*;
#(
  parameter int unsigned HW    = 8,
  parameter int unsigned VW    = 7,
  parameter int unsigned RW    = 5,
  parameter int unsigned AW    = 14,
  parameter int unsigned LOW_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [HW-1:0]             h_total,
  input  logic [HW-1:0]             h_disp,
  input  logic [HW-1:0]             h_sync_pos,
  input  logic [2*SYNC_FIELD_W-1:0] sync_widths,
  input  logic [VW-1:0]             v_total,
  input  logic [RW-1:0]             v_adjust,
  input  logic [VW-1:0]             v_disp,
  input  logic [VW-1:0]             v_sync_pos,
  input  logic [RW-1:0]             max_raster,
  input  logic [AW-LOW_W-1:0]       start_hi,
  input  logic [LOW_W-1:0]          start_lo,
  output logic                      hsync,
  output logic                      vsync,
  output logic                      disp_en,
  output logic [AW-1:0]             mem_addr,
  output logic [RW-1:0]             row_addr
);

  logic [HW-1:0] hcc;
  logic          line_end;
  logic          row_last;
  logic          frame_start;
  logic          vdisp;
  logic [AW-1:0] start_addr;

  assign start_addr = {start_hi, start_lo};
  assign disp_en    = (hcc < h_disp) && vdisp;

  crt_hcount #(.HW(HW)) u_h (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_total    (h_total),
    .h_sync_pos (h_sync_pos),
    .hs_field   (sync_widths[SYNC_FIELD_W-1:0]),
    .hcc        (hcc),
    .line_end   (line_end),
    .hsync      (hsync)
  );

  crt_vcount #(.RW(RW), .VW(VW)) u_v (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_end    (line_end),
    .line_start  (hcc == '0),
    .max_raster  (max_raster),
    .v_total     (v_total),
    .v_adjust    (v_adjust),
    .v_disp      (v_disp),
    .v_sync_pos  (v_sync_pos),
    .vs_field    (sync_widths[2*SYNC_FIELD_W-1:SYNC_FIELD_W]),
    .rc          (row_addr),
    .row_last    (row_last),
    .frame_start (frame_start),
    .vdisp       (vdisp),
    .vsync       (vsync)
  );

  crt_addr_gen #(.AW(AW), .HW(HW)) u_a (
    .clk         (clk),
    .rst_n       (rst_n),
    .hcc         (hcc),
    .h_disp      (h_disp),
    .line_end    (line_end),
    .row_last    (row_last),
    .frame_start (frame_start),
    .start_addr  (start_addr),
    .ma          (mem_addr)
  );

  // R2
  blank_outside_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_addr > max_raster) |-> !disp_en);

endmodule

// File: tb/crt_raster_gen_tb_top.sv
`timescale 1ns/1ps
module crt_raster_gen_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] h_total, h_disp, h_sync_pos, sync_widths, start_lo;
  logic [6:0] v_total, v_disp, v_sync_pos;
  logic [4:0] v_adjust, max_raster;
  logic [5:0] start_hi;
  logic hsync, vsync, disp_en;
  logic [13:0] mem_addr;
  logic [4:0] row_addr;

  always #2.5 clk = ~clk;

  crt_raster_gen dut_i (
    .clk(clk), .rst_n(rst_n), .h_total(h_total), .h_disp(h_disp),
    .h_sync_pos(h_sync_pos), .sync_widths(sync_widths), .v_total(v_total),
    .v_adjust(v_adjust), .v_disp(v_disp), .v_sync_pos(v_sync_pos),
    .max_raster(max_raster), .start_hi(start_hi), .start_lo(start_lo),
    .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .mem_addr(mem_addr),
    .row_addr(row_addr)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_h, m_r, m_v, m_hs, m_vs, m_ma, m_row;
  bit m_adj;

  function automatic int start_val();
    return (int'(start_hi) << 8) | int'(start_lo);
  endfunction
  function automatic int len_of(input int f);
    return (f == 0) ? 16 : f;
  endfunction
  function automatic bit vs_begin();
    return (m_h == 0) && (m_r == 0) && !m_adj && (m_v == int'(v_sync_pos)) && (m_vs == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h = 0; m_r = 0; m_v = 0; m_adj = 0; m_hs = 0; m_vs = 0;
      m_ma = start_val(); m_row = start_val();
    end else begin
      bit le, last, cap, vb;
      int nrow;
      le   = (m_h == int'(h_total));
      last = (!m_adj && m_r == int'(max_raster) && m_v == int'(v_total) && v_adjust == 0) ||
             (m_adj && m_r == int'(v_adjust) - 1);
      cap  = !m_adj && (m_r == int'(max_raster)) && (m_h == int'(h_disp));
      vb   = vs_begin();
      if (m_h == int'(h_sync_pos)) m_hs = len_of(int'(sync_widths[3:0])) - 1;
      else if (m_hs > 0) m_hs--;
      if (vb) m_vs = le ? len_of(int'(sync_widths[7:4])) - 1 : len_of(int'(sync_widths[7:4]));
      else if (le && m_vs > 0) m_vs--;
      nrow = cap ? m_ma : m_row;
      if (le && last) begin
        m_ma = start_val(); nrow = start_val();
      end else if (le) begin
        m_ma = cap ? m_ma : m_row;
      end else begin
        m_ma = (m_ma + 1) % 16384;
      end
      m_row = nrow;
      if (le) begin
        if (last) begin m_r = 0; m_v = 0; m_adj = 0; end
        else if (m_adj) m_r++;
        else if (m_r == int'(max_raster)) begin
          m_r = 0;
          if (m_v == int'(v_total)) m_adj = 1; else m_v++;
        end else m_r++;
        m_h = 0;
      end else m_h++;
    end
  end

  // Per-cycle comparison and period/width measurement
  bit run_on = 0;
  int cyc, hs_rise, vs_rise, hs_period, vs_period, hs_width, vs_width;
  bit hs_prev, vs_prev;

  always @(negedge clk) begin
    if (rst_n && run_on) begin
      chk("R3 hsync", int'(hsync), int'((m_h == int'(h_sync_pos)) || m_hs > 0));
      chk("R4 vsync", int'(vsync), int'(vs_begin() || m_vs > 0));
      chk("R2 disp_en", int'(disp_en),
          int'(m_h < int'(h_disp) && !m_adj && m_v < int'(v_disp)));
      chk("R8 mem_addr", int'(mem_addr), m_ma);
      chk("R5 row_addr", int'(row_addr), m_r);
      if (m_h == 0 && m_r == 0 && m_v == 0 && !m_adj)
        chk("R7 top address", int'(mem_addr), start_val());
      cyc++;
      if (hsync && !hs_prev) begin
        if (hs_rise >= 0) hs_period = cyc - hs_rise;
        hs_rise = cyc;
      end
      if (!hsync && hs_prev) hs_width = cyc - hs_rise;
      if (vsync && !vs_prev) begin
        if (vs_rise >= 0) vs_period = cyc - vs_rise;
        vs_rise = cyc;
      end
      if (!vsync && vs_prev) vs_width = cyc - vs_rise;
      hs_prev = hsync;
      vs_prev = vsync;
    end
  end

  task automatic run_cfg(input int ht, input int hd, input int hp, input int sw,
                         input int vt, input int va, input int vd, input int vp,
                         input int mr, input int st, input int ncyc);
    @(negedge clk);
    run_on = 0;
    rst_n = 0;
    h_total = 8'(ht); h_disp = 8'(hd); h_sync_pos = 8'(hp); sync_widths = 8'(sw);
    v_total = 7'(vt); v_adjust = 5'(va); v_disp = 7'(vd); v_sync_pos = 7'(vp);
    max_raster = 5'(mr); start_hi = 6'(st >> 8); start_lo = 8'(st & 255);
    repeat (3) @(negedge clk);
    // R9: reset state seen at the ports
    chk("R9 reset mem_addr", int'(mem_addr), st);
    chk("R9 reset row_addr", int'(row_addr), 0);
    chk("R9 reset hsync", int'(hsync), int'(hp == 0));
    chk("R9 reset disp_en", int'(disp_en), int'(hd > 0 && vd > 0));
    cyc = 0; hs_rise = -1; vs_rise = -1;
    hs_period = -1; vs_period = -1; hs_width = -1; vs_width = -1;
    hs_prev = 0; vs_prev = 0;
    rst_n = 1;
    run_on = 1;
    repeat (ncyc) @(negedge clk);
    #1;
  endtask

  initial begin
    // Default programming: 64-character lines, 312-line frame
    run_cfg(63, 40, 46, 8'h8E, 38, 0, 25, 30, 7, 14'h2000, 36000);
    chk("R1 R10 line period", hs_period, 64);
    chk("R6 R10 frame period", vs_period, 19968);
    chk("R3 hsync width 14", hs_width, 14);
    chk("R4 vsync width 8 lines", vs_width, 8 * 64);

    // Small frame with adjust lines and a start address that wraps
    run_cfg(9, 6, 7, 8'h31, 4, 3, 3, 2, 2, 14'h3FF0, 1000);
    chk("R1 line period 10", hs_period, 10);
    chk("R6 frame period with adjust", vs_period, (5 * 3 + 3) * 10);
    chk("R3 hsync width 1", hs_width, 1);
    chk("R4 vsync width 3 lines", vs_width, 30);

    // Zero width fields mean 16; blanking row beyond the last row
    run_cfg(39, 40, 20, 8'h00, 9, 0, 12, 2, 1, 14'h0123, 3000);
    chk("R1 line period 40", hs_period, 40);
    chk("R6 frame period 20 lines", vs_period, 800);
    chk("R3 hsync width zero field", hs_width, 16);
    chk("R4 vsync width zero field", vs_width, 16 * 40);

    // Display end on the last column, one-raster rows, one adjust line
    run_cfg(7, 7, 0, 8'h12, 2, 1, 2, 0, 0, 14'h0100, 500);
    chk("R1 line period 8", hs_period, 8);
    chk("R6 frame period 4 lines", vs_period, 32);
    chk("R3 hsync width 2", hs_width, 2);

    run_on = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule